// File: doc/BRIEF.md
# Display-Synchronized Keyboard Scanner

This block reads a 128-key switch matrix without a scan counter of its own. The 7-bit key address it drives out is built from two parts. The three low bits are the scan-line count supplied by the display controller. The four high bits come from a column counter that steps once at the end of each display row. While the scan line walks through its eight values, the block samples the sense input once per line and shifts the samples into an 8-bit group. At the end of a row, the completed group is latched. The processor then reads it at the key-status port, where a set bit marks a pressed key.

A frame-start strobe returns the column counter to zero. The first sixteen rows of a frame then cover all sixteen columns, and the counter stays at its top value until the next frame. Software can also write the column port to place the counter on any column, which allows a scan driven by software.

Top module: `kbd_scanner`

## Requirements
- R1: After reset the column counter is 0, the key-status port reads 0x00, the column port reads 0x00, and the key address equals {4'b0, scan_line}.
- R2: The key address is combinational. Bits 6:3 carry the column counter and bits 2:0 carry the scan_line input in the same cycle.
- R3: Whenever scan_line differs from its value on the previous clock, the sense level registered during the previous line is shifted into the group at the top bit, and the older bits move toward bit 0. After the lines step 0→1→…→7→0, bit i of the group holds the state of row i of the column. 1 means pressed.
- R4: A frame_start pulse loads the column counter with 0 on the next edge. It takes priority over a column write and over row_adv.
- R5: A row_adv pulse without frame_start or a column write increments the column counter by one. At 15 the counter holds until the next frame_start.
- R6: A write to address 0xB8 loads the column counter from cpu_wdata[3:0] and takes priority over row_adv. A read of 0xB8 returns the counter in bits 3:0, with zeros above.
- R7: On a row_adv edge the group is latched, including any shift made at that same edge. A read of address 0x80 returns the latched group from the next cycle, and the value holds until the next row_adv.
- R8: A write to 0x80 has no effect on the status or the column. A read of any address other than 0x80 or 0xB8 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_line | input | 3 | Scan-line count from the display controller |
| row_adv | input | 1 | One-cycle pulse at the end of a display row |
| frame_start | input | 1 | One-cycle pulse at the start of a frame |
| key_sense | input | 1 | State of the addressed key, high when pressed |
| key_addr | output | 7 | Key address to the matrix decoder |
| cpu_addr | input | 8 | Processor port address |
| cpu_wr | input | 1 | Port write strobe |
| cpu_wdata | input | 8 | Port write data |
| cpu_rdata | output | 8 | Port read data, combinational on cpu_addr |

## Verification
The key address follows scan_line in the same cycle, so the bench checks it shortly after driving a new line. A column change from frame_start, row_adv or a port write appears after one clock edge. The latched group is readable one edge after the row_adv cycle, because the sample register and the shift both lie before the latch. The driver pushes the expected group for each row into a queue. The monitor pops that entry 2 ns after the row_adv edge, and all stimulus changes only on falling edges, so no check races a drive.

// File: rtl/kbd_scanner.sv
module kbd_scanner #(
  parameter int COL_W = 4,
  parameter int ROW_W = 3,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_PORT = 8'h80,
  parameter logic [ADDR_W-1:0] COL_PORT = 8'hB8,
  localparam int GRP_W = 1 << ROW_W,
  localparam int KEY_W = COL_W + ROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ROW_W-1:0]  scan_line,
  input  logic              row_adv,
  input  logic              frame_start,
  input  logic              key_sense,
  output logic [KEY_W-1:0]  key_addr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic [GRP_W-1:0]  cpu_wdata,
  output logic [GRP_W-1:0]  cpu_rdata
);
  localparam logic [COL_W-1:0] COL_MAX = '1;

  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] line_q;
  logic             sense_q;
  logic [GRP_W-1:0] shift_q, status_q, shift_nxt;

  wire line_chg = scan_line != line_q;
  wire wr_col   = cpu_wr && (cpu_addr == COL_PORT);

  assign key_addr  = {col_q, scan_line};
  assign shift_nxt = line_chg ? {sense_q, shift_q[GRP_W-1:1]} : shift_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q    <= '0;
      line_q   <= '0;
      sense_q  <= 1'b0;
      shift_q  <= '0;
      status_q <= '0;
    end else begin
      line_q  <= scan_line;
      sense_q <= key_sense;
      shift_q <= shift_nxt;
      if (row_adv) status_q <= shift_nxt;
      if (frame_start)                   col_q <= '0;
      else if (wr_col)                   col_q <= cpu_wdata[COL_W-1:0];
      else if (row_adv && col_q != COL_MAX) col_q <= col_q + 1'b1;
    end
  end

  always_comb begin
    cpu_rdata = '0;
    if (cpu_addr == STAT_PORT)     cpu_rdata = status_q;
    else if (cpu_addr == COL_PORT) cpu_rdata[COL_W-1:0] = col_q;
  end
endmodule

module kbd_scanner_chk #(
  parameter int COL_W = 4,
  parameter int GRP_W = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] COL_PORT = 8'hB8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              row_adv,
  input logic              frame_start,
  input logic              cpu_wr,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [GRP_W-1:0]  cpu_wdata,
  input logic [COL_W-1:0]  col,
  input logic [GRP_W-1:0]  status
);
  wire wr_c = cpu_wr && (cpu_addr == COL_PORT);
  wire top  = &col;

  AST_FRAME_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> col == '0); // R4
  AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (row_adv && !frame_start && !wr_c && !top) |=> col == $past(col) + 1'b1); // R5
  AST_COL_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (row_adv && !frame_start && !wr_c && top) |=> &col); // R5
  AST_SW_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_c && !frame_start) |=> col == $past(cpu_wdata[COL_W-1:0])); // R6
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !row_adv |=> $stable(status)); // R7
endmodule

bind kbd_scanner kbd_scanner_chk #(.COL_W(COL_W), .GRP_W(GRP_W), .ADDR_W(ADDR_W), .COL_PORT(COL_PORT)) u_chk (
  .clk(clk), .rst_n(rst_n), .row_adv(row_adv), .frame_start(frame_start),
  .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .col(col_q), .status(status_q));

// File: tb/kbd_scanner_tb.sv
module kbd_scanner_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] scan_line = '0;
  logic row_adv = 1'b0, frame_start = 1'b0, cpu_wr = 1'b0;
  logic [7:0] cpu_addr = 8'h80, cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic [6:0] key_addr;
  logic [127:0] kmap = '0;
  logic key_sense;
  logic [7:0] exp_q[$];
  logic [7:0] last_grp = '0;
  int col_m = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;
  assign key_sense = kmap[key_addr];

  kbd_scanner u_dut (.clk(clk), .rst_n(rst_n), .scan_line(scan_line), .row_adv(row_adv),
    .frame_start(frame_start), .key_sense(key_sense), .key_addr(key_addr),
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic read_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk) cpu_addr = a;
    #1 chk(req, cpu_rdata, exp);
    cpu_addr = 8'h80;
  endtask

  task automatic start_frame();
    @(negedge clk) begin frame_start = 1'b1; scan_line = '0; end
    @(negedge clk) frame_start = 1'b0;
    col_m = 0;
  endtask

  task automatic do_row();
    exp_q.push_back(kmap[col_m*8 +: 8]);
    last_grp = kmap[col_m*8 +: 8];
    for (int l = 1; l < 8; l++) begin
      @(negedge clk) scan_line = 3'(l);
      if (l == 3) begin #1 chk("R2", key_addr, {col_m[3:0], 3'd3}); end
    end
    @(negedge clk) begin scan_line = '0; row_adv = 1'b1; end
    @(negedge clk) row_adv = 1'b0;
    if (col_m < 15) col_m++;
  endtask

  task automatic cpu_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk) begin cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; end
    @(negedge clk) begin cpu_wr = 1'b0; cpu_addr = 8'h80; end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && row_adv) begin
        #2;
        if (exp_q.size() == 0) chk("R7 queue", 1, 0);
        else chk("R3 R7", cpu_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) kmap[i] = ((i * 7 + 3) % 5) < 2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk) scan_line = 3'd5;
    #1 chk("R1 key_addr", key_addr, 7'd5);
    chk("R1 status", cpu_rdata, 8'h00);
    read_chk("R1 column", 8'hB8, 8'h00);
    @(negedge clk) scan_line = '0;

    start_frame();
    repeat (18) do_row();
    read_chk("R5 saturate", 8'hB8, 8'h0F);

    kmap = ~kmap;
    start_frame();
    repeat (3) do_row();
    start_frame();
    #1 chk("R4 frame clear", key_addr[6:3], 4'd0);
    repeat (2) do_row();
    read_chk("R5 step", 8'hB8, 8'h02);

    cpu_write(8'hB8, 8'hF9);
    col_m = 9;
    read_chk("R6 readback", 8'hB8, 8'h09);
    #1 chk("R6 key_addr", key_addr[6:3], 4'd9);
    do_row();
    read_chk("R6 step after write", 8'hB8, 8'h0A);

    cpu_write(8'h80, 8'hFF);
    read_chk("R8 status unchanged", 8'h80, last_grp);
    read_chk("R8 column unchanged", 8'hB8, 8'h0A);
    read_chk("R8 unmapped", 8'h11, 8'h00);

    kmap = '0;
    kmap[9*8 + 5] = 1'b1;
    cpu_write(8'hB8, 8'h09);
    col_m = 9;
    do_row();
    read_chk("R3 single key bit5", 8'h80, 8'h20);
    repeat (2) @(negedge clk);
    read_chk("R7 hold", 8'h80, 8'h20);

    chk("R7 queue drained", exp_q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule